// File: doc/BRIEF.md
# Bus Strobe Decoder and Address Splitter

This block sits between a simple processor bus and the memory and peripherals behind it. The bus carries an address, one combined read-not-write line, an enable strobe and a space qualifier. The block turns these into four active-low strobes: memory read, memory write, peripheral read and peripheral write. It also passes the low address bits to the peripherals as a short address, so that peripherals compare only those bits.

A parameter picks how the space is split. In isolated-space mode, the qualifier input chooses memory or peripherals for the whole address range. In memory-mapped mode, the top address bit makes the choice: the lower half goes to memory, the upper half to peripherals, and the qualifier is ignored.

The block also checks two bus timing rules and keeps sticky flags that a testbench can watch. The first rule is that the address must be held for a setup number of cycles before enable rises. The second is that during a read, the responder must show valid data within a bounded number of cycles after enable.

Top module: `bus_strobe_decoder`

## Requirements
- R1: A cycle is a read when `rd_nwr` is 0 and a write when it is 1. A read strobe is low only while `en` is 1 and `rd_nwr` is 0. A write strobe is low only while `en` is 1 and `rd_nwr` is 1. Strobes are combinational from the inputs.
- R2: With `MEM_MAPPED`=0, `io_sel`=0 sends every address to the memory strobes and `io_sel`=1 sends every address to the peripheral strobes.
- R3: With `MEM_MAPPED`=1, addresses with bit 15 equal to 0 drive the memory strobes, and addresses with bit 15 equal to 1 drive the peripheral strobes. `io_sel` has no effect on any output.
- R4: While `en` is 0, all four strobes are 1.
- R5: No more than one strobe is 0 in any cycle.
- R6: `periph_addr` equals the low `PERIPH_W` bits (default 8) of `addr`. Higher address bits have no effect on it.
- R7: At a clock edge where `en` is 1 and was 0 at the previous edge, the address is checked. If it was equal at fewer than `SETUP_CYC` (default 2) immediately preceding edges, `setup_viol` becomes 1 after that edge.
- R8: During a read, edges with `en` at 1 are counted from the first one. If `data_ok` is 0 at each of the first `READ_DLY_CYC` (default 3) of these edges, `rdly_viol` becomes 1 after the last of them. If `data_ok` is seen earlier, the flag stays 0.
- R9: Both flags are 0 after reset. Once set, they stay 1 until reset. Bus cycles that meet both rules leave them at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Bus address |
| rd_nwr | input | 1 | 0 = read, 1 = write |
| en | input | 1 | Bus enable strobe, active high |
| io_sel | input | 1 | Space qualifier, 1 = peripheral space (isolated mode only) |
| data_ok | input | 1 | Responder has read data valid |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | Peripheral read strobe, active low |
| io_wr_n | output | 1 | Peripheral write strobe, active low |
| periph_addr | output | PERIPH_W | Low address bits for peripheral decoding |
| setup_viol | output | 1 | Sticky address setup violation flag |
| rdly_viol | output | 1 | Sticky read data delay violation flag |

## Verification
Random stimulus changes the address almost every cycle, so it never produces a legal, flag-free bus cycle. A clean cycle needs the address held across several idle edges, then enable raised, then `data_ok` returned within the bound. Directed sequences after a fresh reset build exactly that. They then move one edge at a time to just inside and just past each limit, with the flag sampled after each edge. The memory-mapped variant runs beside the default one on the same inputs. This shows both decodings, and that the qualifier is ignored, under identical stimulus.

// File: rtl/bus_strobe_decoder.sv
module bus_strobe_decoder #(
  parameter int ADDR_W       = 16,
  parameter bit MEM_MAPPED   = 1'b0,
  parameter int PERIPH_W     = 8,
  parameter int SETUP_CYC    = 2,
  parameter int READ_DLY_CYC = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                rd_nwr,
  input  logic                en,
  input  logic                io_sel,
  input  logic                data_ok,
  output logic                mem_rd_n,
  output logic                mem_wr_n,
  output logic                io_rd_n,
  output logic                io_wr_n,
  output logic [PERIPH_W-1:0] periph_addr,
  output logic                setup_viol,
  output logic                rdly_viol
);

  localparam int HW = $clog2(SETUP_CYC + 1) + 1;
  localparam int RW = $clog2(READ_DLY_CYC + 1) + 1;
  localparam logic [HW-1:0] SETUP_LIM = HW'(SETUP_CYC);
  localparam logic [RW-1:0] RD_LAST   = RW'(READ_DLY_CYC - 1);

  logic io_space;
  logic unused_sel;

  generate
    if (MEM_MAPPED) begin : g_mm
      assign io_space   = addr[ADDR_W-1];
      assign unused_sel = io_sel;
    end else begin : g_iso
      assign io_space   = io_sel;
      assign unused_sel = 1'b0;
    end
  endgenerate

  assign mem_rd_n    = ~(en & ~rd_nwr & ~io_space);
  assign mem_wr_n    = ~(en &  rd_nwr & ~io_space);
  assign io_rd_n     = ~(en & ~rd_nwr &  io_space);
  assign io_wr_n     = ~(en &  rd_nwr &  io_space);
  assign periph_addr = addr[PERIPH_W-1:0];

  logic [ADDR_W-1:0] addr_q;
  logic [HW-1:0]     hold_q, hold_d;
  logic              en_q;

  assign hold_d = (addr != addr_q) ? '0 :
                  (hold_q >= SETUP_LIM) ? hold_q : hold_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      hold_q     <= '0;
      en_q       <= 1'b0;
      setup_viol <= 1'b0;
    end else begin
      addr_q <= addr;
      hold_q <= hold_d;
      en_q   <= en;
      if (en && !en_q && hold_d < SETUP_LIM) setup_viol <= 1'b1;
    end
  end

  logic [RW-1:0] wait_q;
  logic          done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q    <= '0;
      done_q    <= 1'b0;
      rdly_viol <= 1'b0;
    end else if (!en || rd_nwr) begin
      wait_q <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (data_ok) begin
        done_q <= 1'b1;
      end else if (wait_q == RD_LAST) begin
        rdly_viol <= 1'b1;
        done_q    <= 1'b1;
      end else begin
        wait_q <= wait_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/bus_strobe_decoder_chk.sv
module bus_strobe_decoder_chk #(
  parameter int ADDR_W    = 16,
  parameter int SETUP_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_nwr,
  input logic              en,
  input logic              mem_rd_n,
  input logic              mem_wr_n,
  input logic              io_rd_n,
  input logic              io_wr_n,
  input logic              setup_viol,
  input logic              rdly_viol
);

  p_rd_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd_n || !io_rd_n) |-> (en && !rd_nwr));

  p_wr_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wr_n || !io_wr_n) |-> (en && rd_nwr));

  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (mem_rd_n && mem_wr_n && io_rd_n && io_wr_n));

  p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~mem_rd_n, ~mem_wr_n, ~io_rd_n, ~io_wr_n}) <= 1);

  p_setup_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (SETUP_CYC > 0 && $rose(en) && !$stable(addr)) |=> setup_viol);

  p_rdly_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdly_viol) |-> ($past(en) && !$past(rd_nwr)));

  p_setup_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    setup_viol |=> setup_viol);

  p_rdly_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rdly_viol |=> rdly_viol);

endmodule

bind bus_strobe_decoder bus_strobe_decoder_chk #(
  .ADDR_W(ADDR_W), .SETUP_CYC(SETUP_CYC)
) chk_i (.*);

// File: tb/bus_strobe_decoder_tb_top.sv
module bus_strobe_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic rd_nwr = 1'b0, en = 1'b0, io_sel = 1'b0, data_ok = 1'b0;
  logic mr, mw, ir, iw, sv, rv;
  logic mr2, mw2, ir2, iw2, sv2, rv2;
  logic [7:0] pa, pa2;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  bus_strobe_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_nwr(rd_nwr), .en(en),
    .io_sel(io_sel), .data_ok(data_ok), .mem_rd_n(mr), .mem_wr_n(mw),
    .io_rd_n(ir), .io_wr_n(iw), .periph_addr(pa), .setup_viol(sv), .rdly_viol(rv));

  bus_strobe_decoder #(.MEM_MAPPED(1'b1)) dut_mm_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_nwr(rd_nwr), .en(en),
    .io_sel(io_sel), .data_ok(data_ok), .mem_rd_n(mr2), .mem_wr_n(mw2),
    .io_rd_n(ir2), .io_wr_n(iw2), .periph_addr(pa2), .setup_viol(sv2), .rdly_viol(rv2));

  function automatic logic [3:0] exp_strb(logic e, logic rnw, logic sel, logic [15:0] a, bit mm);
    logic io;
    io = mm ? a[15] : sel;
    return ~{e & ~rnw & ~io, e & rnw & ~io, e & ~rnw & io, e & rnw & io};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_comb(string req);
    #1;
    chk(req, {28'h0, mr, mw, ir, iw}, {28'h0, exp_strb(en, rd_nwr, io_sel, addr, 1'b0)});
    chk(req, {28'h0, mr2, mw2, ir2, iw2}, {28'h0, exp_strb(en, rd_nwr, io_sel, addr, 1'b1)});
  endtask

  task automatic do_reset();
    en = 1'b0; data_ok = 1'b0; rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    do_reset();
    // R9 reset state, R4 idle
    chk("R9 reset setup", {31'h0, sv}, 32'h0);
    chk("R9 reset rdly", {31'h0, rv}, 32'h0);
    check_comb("R4 idle after reset");

    // directed: R3 boundary around the top bit, with io_sel both ways
    foreach (addr[i]) begin end
    for (int k = 0; k < 8; k++) begin
      addr = (k[1:0] == 0) ? 16'h7FFF : (k[1:0] == 1) ? 16'h8000 :
             (k[1:0] == 2) ? 16'h0000 : 16'hFFFF;
      io_sel = k[2]; en = 1'b1; rd_nwr = k[0];
      check_comb("R3 mapped boundary");
    end
    // R2: io_sel picks space for extreme addresses
    for (int k = 0; k < 4; k++) begin
      addr = k[0] ? 16'hFFFF : 16'h0000; io_sel = k[1]; en = 1'b1; rd_nwr = 1'b0;
      check_comb("R2 isolated select");
    end
    // R6: high bits do not reach periph_addr
    addr = 16'hA55A; #1 chk("R6 periph low bits", {24'h0, pa}, 32'h5A);
    addr = 16'h005A; #1 chk("R6 high bits ignored", {24'h0, pa}, 32'h5A);

    // random phase: R1, R2, R3, R4, R5, R6
    for (int k = 0; k < 400; k++) begin
      addr = 16'($urandom); rd_nwr = 1'($urandom); en = 1'($urandom);
      io_sel = 1'($urandom); data_ok = 1'($urandom);
      check_comb("R1 R2 R3 R4 random decode");
      chk("R5 one strobe", {30'h0, 2'($countones({~mr, ~mw, ~ir, ~iw}) > 1)}, 32'h0);
      chk("R6 random periph", {24'h0, pa}, {24'h0, addr[7:0]});
      step();
    end

    // R8/R9: legal read, data on second enabled edge
    do_reset();
    addr = 16'h1234; rd_nwr = 1'b0; io_sel = 1'b0;
    step(); step(); step();
    en = 1'b1; step();
    data_ok = 1'b1; step();
    data_ok = 1'b0; step(); step();
    en = 1'b0; step();
    chk("R9 clean read setup", {31'h0, sv}, 32'h0);
    chk("R8 clean read rdly", {31'h0, rv}, 32'h0);

    // R7: exactly SETUP_CYC edges of hold is legal
    addr = 16'h2222; rd_nwr = 1'b1;
    step(); step();
    en = 1'b1; step();
    chk("R7 setup at limit", {31'h0, sv}, 32'h0);
    en = 1'b0; step();

    // R7: one edge short sets the flag
    addr = 16'h3333;
    step();
    en = 1'b1; step();
    chk("R7 setup one short", {31'h0, sv}, 32'h1);
    en = 1'b0; step(); step();
    chk("R9 setup sticky", {31'h0, sv}, 32'h1);
    chk("R7 write no rdly", {31'h0, rv}, 32'h0);

    // R8: read with no data; flag after the READ_DLY_CYC-th edge
    do_reset();
    addr = 16'h4444; rd_nwr = 1'b0;
    step(); step(); step();
    en = 1'b1; step(); step();
    chk("R8 before limit", {31'h0, rv}, 32'h0);
    step();
    chk("R8 after limit", {31'h0, rv}, 32'h1);
    en = 1'b0; step(); step();
    chk("R9 rdly sticky", {31'h0, rv}, 32'h1);

    // R8: data at the last allowed edge is in time
    do_reset();
    addr = 16'h5555; rd_nwr = 1'b0;
    step(); step(); step();
    en = 1'b1; step(); step();
    data_ok = 1'b1; step();
    data_ok = 1'b0; step();
    chk("R8 data at last edge", {31'h0, rv}, 32'h0);
    en = 1'b0; step();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule